// File: doc/BRIEF.md
# Two-Cycle Register-File Processor Core

This block is a 16-bit processor core. Sixteen general registers sit behind a single ALU, and that ALU sits between the register file and the address and data buses. Every instruction takes two clock cycles. In FETCH, the core reads the instruction word and steps the program counter. In EXECUTE, it carries out that word.

The program counter is not a dedicated register. It is one of the general registers, chosen by a parameter. During FETCH the ALU adds a forced constant of two to it, so there is no separate incrementer. Because that register is general, an ordinary register write into it acts as an absolute jump. A memory read that names it as the address returns the word that follows the instruction.

The core drives a zero-wait memory and byte I/O port. It places an address and a strobe on the bus and takes the read data in the same cycle. Moving bytes between the two halves of the data bus is left to the memory side. The sequencer has three states:
- START is held in reset. It writes 0000h into the program counter and always moves on to FETCH.
- FETCH always moves on to EXEC.
- EXEC always returns to FETCH.

Top module: `duo_cpu`

## Requirements
- R1: After reset is released, the core spends one START cycle with no strobe active. The program counter register then holds 0000h, and the next cycle is a FETCH from address 0000h.
- R2: FETCH and EXEC cycles alternate. In FETCH, mem_addr equals the program counter register (index PC_IDX, default 15) and mem_re is 1. The instruction register loads mem_rdata, and the program counter register becomes its old value plus 2.
- R3: Opcode 7 (IR[15:12]) writes f(RB, RA) into RB. RB is IR[7:4], RA is IR[3:0], and f is selected by IR[11:8]:
  - 0: A+B
  - 1: A-B
  - 2: AND
  - 3: OR
  - 4: XOR
  - 5: copy B
  - 6: invert B
  - 7: A shifted right by one, logically
  - 8: A shifted left by one
  - 9 to F: A unchanged
- R4: Opcode A writes f(RB, IR[3:0] zero-extended) into RB, using the function codes of R3.
- R5: Opcode 3 loads RB from the memory word at address RA. Opcode 5 drives mem_we with address RA and write data RB.
- R6: Opcode 4 raises mem_byte, reads at address RA and writes mem_rdata[7:0] zero-extended into RB. The memory presents the addressed byte in the low lane. Opcode 6 raises mem_byte and mem_we with address RA and write data {00h, RB[7:0]}.
- R7: Opcode 8 sets the zero flag and the negative flag (bit 15) from RB. Opcode 9 sets them from the memory word at address RA. No other instruction changes the flags.
- R8: Opcode B branches when the flag chosen by IR[6] (0 zero, 1 negative) equals IR[7]. The new program counter is the already-incremented value plus twice the sign-extended IR[5:0]. A displacement of -1 therefore re-executes the branch itself.
- R9: Opcode 1 sets the interrupt enable, opcode 2 clears it, and reset clears it. Opcode E branches like R8 only when irq_req is high and the enable is set.
- R10: Opcode C raises io_rd at address RA and writes io_rdata zero-extended into RB. Opcode D raises io_wr at address RA with write data {00h, RB[7:0]} and touches no memory. At most one of mem_re, mem_we, io_rd and io_wr is active in any cycle.
- R11: Opcode F raises bus_rst for exactly its EXEC cycle. Opcode 0, whatever its low 12 bits, changes no register and raises no strobe.
- R12: An EXEC write into the program counter register takes effect at the next FETCH. A word read whose RA is the program counter returns the word directly after the instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Pending interrupt request level |
| mem_addr | output | 16 | Address for memory and I/O cycles |
| mem_rdata | input | 16 | Memory read data, valid in the cycle of mem_re |
| mem_wdata | output | 16 | Write data for memory and I/O |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_byte | output | 1 | Current memory access is a byte access |
| io_rdata | input | 8 | I/O read byte |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| bus_rst | output | 1 | Bus reset pulse |

## Verification
Two register-file writes can target the same register in one instruction: the FETCH increment and an EXECUTE result whose destination is the program counter itself. Two bench programs set up this collision.
- One program moves a computed address into register 15. The EXECUTE write must win over the increment, which the bench judges from the code that runs at the new address and from the marker store that was skipped.
- Another program issues a word read whose address register is the program counter. The freshly incremented value must appear on the bus, which the bench judges by the value that instruction leaves in memory.

The branch pair used to park every program then shows that a displacement of -1 lands back on the branch itself.

// File: rtl/duo_cpu_pkg.sv
package duo_cpu_pkg;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2
    } seq_state_e;

    typedef enum logic [3:0] {
        OP_NOP  = 4'h0, OP_IEN  = 4'h1, OP_IDIS = 4'h2, OP_LDW  = 4'h3,
        OP_LDB  = 4'h4, OP_STW  = 4'h5, OP_STB  = 4'h6, OP_ALU  = 4'h7,
        OP_TSTR = 4'h8, OP_TSTM = 4'h9, OP_IMM  = 4'hA, OP_BCC  = 4'hB,
        OP_INB  = 4'hC, OP_OUTB = 4'hD, OP_BIRQ = 4'hE, OP_BRST = 4'hF
    } opcode_e;

    localparam logic [3:0] FN_ADD  = 4'h0;
    localparam logic [3:0] FN_SUB  = 4'h1;
    localparam logic [3:0] FN_AND  = 4'h2;
    localparam logic [3:0] FN_OR   = 4'h3;
    localparam logic [3:0] FN_XOR  = 4'h4;
    localparam logic [3:0] FN_MOVB = 4'h5;
    localparam logic [3:0] FN_NOTB = 4'h6;
    localparam logic [3:0] FN_SHR  = 4'h7;
    localparam logic [3:0] FN_SHL  = 4'h8;

endpackage

// File: rtl/duo_cpu_alu.sv
module duo_cpu_alu
    import duo_cpu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   fn,
    output logic [W-1:0] y
);

    always_comb begin
        case (fn)
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            FN_MOVB: y = b;
            FN_NOTB: y = ~b;
            FN_SHR:  y = a >> 1;
            FN_SHL:  y = a << 1;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/duo_cpu_regs.sv
module duo_cpu_regs #(
    parameter int W      = 16,
    parameter int N      = 16,
    parameter int PC_IDX = 15,
    localparam int IW    = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ra_idx,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  ra_q,
    output logic [W-1:0]  rb_q,
    output logic [W-1:0]  pc_q
);

    logic [W-1:0] cells [N];

    always_ff @(posedge clk) begin
        if (we) cells[widx] <= wdata;
    end

    assign ra_q = cells[ra_idx];
    assign rb_q = cells[rb_idx];
    assign pc_q = cells[PC_IDX];

endmodule

// File: rtl/duo_cpu_seq.sv
module duo_cpu_seq
    import duo_cpu_pkg::*;
#(
    parameter int W      = 16,
    parameter int N      = 16,
    parameter int PC_IDX = 15,
    localparam int IW    = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_req,
    input  logic [W-1:0]  pc_q,
    input  logic [W-1:0]  ra_q,
    input  logic [W-1:0]  rb_q,
    input  logic [W-1:0]  alu_y,
    input  logic [W-1:0]  mem_rdata,
    input  logic [7:0]    io_rdata,
    output seq_state_e    state_o,
    output logic [IW-1:0] ra_idx,
    output logic [IW-1:0] rb_idx,
    output logic [W-1:0]  alu_a,
    output logic [W-1:0]  alu_b,
    output logic [3:0]    alu_fn,
    output logic          rf_we,
    output logic [IW-1:0] rf_widx,
    output logic [W-1:0]  rf_wdata,
    output logic [W-1:0]  mem_addr,
    output logic [W-1:0]  mem_wdata,
    output logic          mem_re,
    output logic          mem_we,
    output logic          mem_byte,
    output logic          io_rd,
    output logic          io_wr,
    output logic          bus_rst
);

    localparam logic [IW-1:0] PC_SEL = IW'(PC_IDX);

    seq_state_e   state_q, state_d;
    logic [W-1:0] ir_q;
    logic         flag_z, flag_n, irq_en;
    logic         ir_ld, flags_ld, ien_set, ien_clr;
    logic [W-1:0] tst_val;
    opcode_e      op;
    logic         cond_ok;
    logic [W-1:0] disp2, imm_z, rd_byte, io_byte, st_byte;

    assign op      = opcode_e'(ir_q[15:12]);
    assign ra_idx  = ir_q[IW-1:0];
    assign rb_idx  = ir_q[4+IW-1:4];
    assign cond_ok = ((ir_q[6] ? flag_n : flag_z) == ir_q[7]);
    assign disp2   = {{(W-7){ir_q[5]}}, ir_q[5:0], 1'b0};
    assign imm_z   = {{(W-4){1'b0}}, ir_q[3:0]};
    assign rd_byte = {{(W-8){1'b0}}, mem_rdata[7:0]};
    assign io_byte = {{(W-8){1'b0}}, io_rdata};
    assign st_byte = {{(W-8){1'b0}}, rb_q[7:0]};
    assign state_o = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_START;
            ir_q    <= '0;
            flag_z  <= 1'b0;
            flag_n  <= 1'b0;
            irq_en  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ir_ld) ir_q <= mem_rdata;
            if (flags_ld) begin
                flag_z <= (tst_val == '0);
                flag_n <= tst_val[W-1];
            end
            if (ien_set)      irq_en <= 1'b1;
            else if (ien_clr) irq_en <= 1'b0;
        end
    end

    always_comb begin
        state_d   = state_q;
        alu_a     = rb_q;
        alu_b     = ra_q;
        alu_fn    = ir_q[11:8];
        rf_we     = 1'b0;
        rf_widx   = rb_idx;
        rf_wdata  = alu_y;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_byte  = 1'b0;
        io_rd     = 1'b0;
        io_wr     = 1'b0;
        bus_rst   = 1'b0;
        ir_ld     = 1'b0;
        flags_ld  = 1'b0;
        tst_val   = rb_q;
        ien_set   = 1'b0;
        ien_clr   = 1'b0;
        unique case (state_q)
            ST_START: begin
                rf_we    = 1'b1;
                rf_widx  = PC_SEL;
                rf_wdata = '0;
                state_d  = ST_FETCH;
            end
            ST_FETCH: begin
                mem_addr = pc_q;
                mem_re   = 1'b1;
                ir_ld    = 1'b1;
                alu_a    = pc_q;
                alu_b    = W'(2);
                alu_fn   = FN_ADD;
                rf_we    = 1'b1;
                rf_widx  = PC_SEL;
                state_d  = ST_EXEC;
            end
            ST_EXEC: begin
                state_d = ST_FETCH;
                unique case (op)
                    OP_NOP:  ;
                    OP_IEN:  ien_set = 1'b1;
                    OP_IDIS: ien_clr = 1'b1;
                    OP_LDW: begin
                        mem_addr = ra_q; mem_re = 1'b1;
                        rf_we = 1'b1; rf_wdata = mem_rdata;
                    end
                    OP_LDB: begin
                        mem_addr = ra_q; mem_re = 1'b1; mem_byte = 1'b1;
                        rf_we = 1'b1; rf_wdata = rd_byte;
                    end
                    OP_STW: begin
                        mem_addr = ra_q; mem_we = 1'b1; mem_wdata = rb_q;
                    end
                    OP_STB: begin
                        mem_addr = ra_q; mem_we = 1'b1; mem_byte = 1'b1;
                        mem_wdata = st_byte;
                    end
                    OP_ALU:  rf_we = 1'b1;
                    OP_TSTR: flags_ld = 1'b1;
                    OP_TSTM: begin
                        mem_addr = ra_q; mem_re = 1'b1;
                        flags_ld = 1'b1; tst_val = mem_rdata;
                    end
                    OP_IMM: begin
                        alu_b = imm_z; rf_we = 1'b1;
                    end
                    OP_BCC, OP_BIRQ: begin
                        alu_a   = pc_q;
                        alu_b   = disp2;
                        alu_fn  = FN_ADD;
                        rf_widx = PC_SEL;
                        rf_we   = (op == OP_BCC) ? cond_ok : (irq_req && irq_en);
                    end
                    OP_INB: begin
                        mem_addr = ra_q; io_rd = 1'b1;
                        rf_we = 1'b1; rf_wdata = io_byte;
                    end
                    OP_OUTB: begin
                        mem_addr = ra_q; io_wr = 1'b1; mem_wdata = st_byte;
                    end
                    OP_BRST: bus_rst = 1'b1;
                endcase
            end
            default: state_d = ST_START;
        endcase
    end

endmodule

// File: rtl/duo_cpu.sv
module duo_cpu
    import duo_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int N_REGS = 16,
    parameter int PC_IDX = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_re,
    output logic              mem_we,
    output logic              mem_byte,
    input  logic [7:0]        io_rdata,
    output logic              io_rd,
    output logic              io_wr,
    output logic              bus_rst
);

    localparam int IDX_W = $clog2(N_REGS);

    seq_state_e        cur_state;
    logic [IDX_W-1:0]  ra_idx, rb_idx, rf_widx;
    logic [DATA_W-1:0] ra_q, rb_q, pc_q, alu_a, alu_b, alu_y, rf_wdata;
    logic [3:0]        alu_fn;
    logic              rf_we;

    duo_cpu_regs #(.W(DATA_W), .N(N_REGS), .PC_IDX(PC_IDX)) u_regs (
        .clk(clk), .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
        .ra_idx(ra_idx), .rb_idx(rb_idx),
        .ra_q(ra_q), .rb_q(rb_q), .pc_q(pc_q)
    );

    duo_cpu_alu #(.W(DATA_W)) u_alu (
        .a(alu_a), .b(alu_b), .fn(alu_fn), .y(alu_y)
    );

    duo_cpu_seq #(.W(DATA_W), .N(N_REGS), .PC_IDX(PC_IDX)) u_seq (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .pc_q(pc_q), .ra_q(ra_q), .rb_q(rb_q), .alu_y(alu_y),
        .mem_rdata(mem_rdata), .io_rdata(io_rdata),
        .state_o(cur_state), .ra_idx(ra_idx), .rb_idx(rb_idx),
        .alu_a(alu_a), .alu_b(alu_b), .alu_fn(alu_fn),
        .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_we(mem_we), .mem_byte(mem_byte),
        .io_rd(io_rd), .io_wr(io_wr), .bus_rst(bus_rst)
    );

endmodule

// File: rtl/duo_cpu_chk.sv
module duo_cpu_chk
    import duo_cpu_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input seq_state_e   st,
    input logic [W-1:0] pc_q,
    input logic [W-1:0] mem_addr,
    input logic         mem_re,
    input logic         mem_we,
    input logic         io_rd,
    input logic         io_wr,
    input logic         bus_rst
);

    a_r1_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_START) |-> !(mem_re || mem_we || io_rd || io_wr || bus_rst));

    a_r1_start_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_START) |=> (st == ST_FETCH && pc_q == '0));

    a_r2_fetch_to_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH) |=> (st == ST_EXEC));

    a_r2_exec_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EXEC) |=> (st == ST_FETCH));

    a_r2_fetch_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH) |-> (mem_re && !mem_we && !io_rd && !io_wr));

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH) |=> (pc_q == $past(mem_addr) + W'(2)));

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_re, mem_we, io_rd, io_wr}));

    a_r11_brst_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |-> (st == ST_EXEC && !mem_re && !mem_we));

endmodule

bind duo_cpu duo_cpu_chk #(.W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(cur_state), .pc_q(pc_q),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .io_rd(io_rd), .io_wr(io_wr), .bus_rst(bus_rst)
);

// File: tb/test_duo_cpu.sv
module test_duo_cpu;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYC    = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic [15:0] mem_addr, mem_rdata, mem_wdata;
    logic        mem_re, mem_we, mem_byte, io_rd, io_wr, bus_rst;
    logic [7:0]  io_rdata = 8'hC3;

    logic [15:0] img [256];
    logic [15:0] mem [256];
    logic [15:0] cur_word;
    int          brst_cnt, iow_cnt;
    logic [15:0] iow_addr, ior_addr;
    logic [7:0]  iow_data;

    int n_chk = 0;
    int n_fail = 0;
    int org;
    int halt_a;

    always #(CLK_PERIOD/2) clk = ~clk;

    duo_cpu i_duo_cpu (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_we(mem_we), .mem_byte(mem_byte),
        .io_rdata(io_rdata), .io_rd(io_rd), .io_wr(io_wr), .bus_rst(bus_rst)
    );

    assign cur_word  = mem[mem_addr[8:1]];
    assign mem_rdata = mem_byte ? {8'hFF, (mem_addr[0] ? cur_word[15:8] : cur_word[7:0])}
                                : cur_word;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = img[i];
            brst_cnt = 0;
            iow_cnt  = 0;
        end else begin
            if (mem_we) begin
                if (!mem_byte)        mem[mem_addr[8:1]] = mem_wdata;
                else if (mem_addr[0]) mem[mem_addr[8:1]][15:8] = mem_wdata[7:0];
                else                  mem[mem_addr[8:1]][7:0]  = mem_wdata[7:0];
            end
            if (io_wr) begin
                iow_cnt  = iow_cnt + 1;
                iow_addr = mem_addr;
                iow_data = mem_wdata[7:0];
            end
            if (io_rd) ior_addr = mem_addr;
            if (bus_rst) brst_cnt = brst_cnt + 1;
        end
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(logic [3:0] op, logic [3:0] f,
                                        logic [3:0] rb, logic [3:0] ra);
        return {op, f, rb, ra};
    endfunction

    function automatic logic [15:0] bcc(logic tf, logic fs, int d);
        logic [5:0] dd = 6'(d);
        return {4'hB, 4'h0, tf, fs, dd};
    endfunction

    function automatic logic [15:0] birq(int d);
        logic [5:0] dd = 6'(d);
        return {4'hE, 6'h0, dd};
    endfunction

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 16'h0000;
        org = 0;
    endtask

    task automatic emit(logic [15:0] w);
        img[org >> 1] = w;
        org += 2;
    endtask

    task automatic mkbase(logic [3:0] r, logic [3:0] k);
        emit(enc(4'hA, 4'h5, r, k));
        for (int i = 0; i < 5; i++) emit(enc(4'hA, 4'h8, r, 4'h0));
    endtask

    task automatic st(logic [3:0] r);
        emit(enc(4'h5, 4'h0, r, 4'd13));
        emit(enc(4'hA, 4'h0, 4'd13, 4'd2));
    endtask

    task automatic halt();
        halt_a = org;
        emit(bcc(1'b1, 1'b0, -1));
        emit(bcc(1'b0, 1'b0, -1));
    endtask

    task automatic run_prog();
        bit ok = 1'b1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (RUN_CYC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            if (mem_re && mem_addr != 16'(halt_a) && mem_addr != 16'(halt_a + 2)) ok = 1'b0;
            @(negedge clk);
        end
        check("R8 backward branch parks program", {15'h0, ok}, 16'h0001);
    endtask

    function automatic logic [15:0] out_word(int i);
        return mem[(16'h120 >> 1) + i];
    endfunction

    task automatic t_reset();
        clear_img();
        emit(16'h0000);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 strobes in reset", {12'h0, mem_re, mem_we, io_rd, io_wr}, 16'h0000);
        rst_n = 1'b1;
        #1;
        check("R1 START cycle quiet", {14'h0, mem_re, bus_rst}, 16'h0000);
        @(negedge clk);
        check("R1 first FETCH read", {15'h0, mem_re}, 16'h0001);
        check("R1 first FETCH address", mem_addr, 16'h0000);
        @(negedge clk);
        @(negedge clk);
        check("R2 second FETCH address", mem_addr, 16'h0002);
    endtask

    task automatic t_alu();
        logic [15:0] a = 16'h1234;
        logic [15:0] b = 16'h0F0F;
        logic [15:0] exp [12];
        clear_img();
        img[128] = a;
        img[129] = b;
        mkbase(4'd14, 4'd8);
        mkbase(4'd13, 4'd9);
        emit(enc(4'h3, 4'h0, 4'd1, 4'd14));
        emit(enc(4'hA, 4'h0, 4'd14, 4'd2));
        emit(enc(4'h3, 4'h0, 4'd2, 4'd14));
        for (int f = 0; f < 5; f++) begin
            emit(enc(4'h7, 4'h5, 4'd3, 4'd1));
            emit(enc(4'h7, 4'(f), 4'd3, 4'd2));
            st(4'd3);
        end
        emit(enc(4'h7, 4'h6, 4'd3, 4'd2)); st(4'd3);
        emit(enc(4'h7, 4'h5, 4'd3, 4'd1)); emit(enc(4'h7, 4'h7, 4'd3, 4'd0)); st(4'd3);
        emit(enc(4'h7, 4'h5, 4'd3, 4'd1)); emit(enc(4'h7, 4'h8, 4'd3, 4'd0)); st(4'd3);
        emit(enc(4'h7, 4'h5, 4'd3, 4'd1)); emit(enc(4'h7, 4'hC, 4'd3, 4'd2)); st(4'd3);
        emit(enc(4'hA, 4'h5, 4'd4, 4'd7));
        emit(enc(4'hA, 4'h0, 4'd4, 4'd9));  st(4'd4);
        emit(enc(4'hA, 4'h1, 4'd4, 4'd15)); st(4'd4);
        emit(enc(4'hA, 4'h1, 4'd4, 4'd2));  st(4'd4);
        halt();
        exp = '{a + b, a - b, a & b, a | b, a ^ b, ~b, a >> 1, a << 1, a,
                16'd16, 16'd1, 16'hFFFF};
        run_prog();
        for (int i = 0; i < 9; i++) check($sformatf("R3 alu function slot %0d", i), out_word(i), exp[i]);
        for (int i = 9; i < 12; i++) check($sformatf("R4 immediate slot %0d", i), out_word(i), exp[i]);
        check("R5 word read and write", out_word(8), a);
    endtask

    task automatic t_bytes();
        clear_img();
        img[128] = 16'hA55A;
        img[129] = 16'h1234;
        img[160] = 16'hBEEF;
        mkbase(4'd14, 4'd8);
        mkbase(4'd13, 4'd9);
        mkbase(4'd12, 4'd10);
        emit(enc(4'h4, 4'h0, 4'd1, 4'd14)); st(4'd1);
        emit(enc(4'hA, 4'h0, 4'd14, 4'd1));
        emit(enc(4'h4, 4'h0, 4'd2, 4'd14)); st(4'd2);
        emit(enc(4'hA, 4'h0, 4'd14, 4'd1));
        emit(enc(4'h3, 4'h0, 4'd3, 4'd14));
        emit(enc(4'h6, 4'h0, 4'd3, 4'd12));
        emit(enc(4'hA, 4'h0, 4'd12, 4'd1));
        emit(enc(4'h6, 4'h0, 4'd3, 4'd12));
        halt();
        run_prog();
        check("R6 byte read even address", out_word(0), 16'h005A);
        check("R6 byte read odd address", out_word(1), 16'h00A5);
        check("R6 byte writes both lanes", mem[160], 16'h3434);
    endtask

    task automatic cond_block(logic [3:0] test_op, logic [3:0] reg_idx, logic tf, logic fs);
        emit(enc(4'hA, 4'h5, 4'd5, 4'd0));
        if (test_op == 4'h8) emit(enc(4'h8, 4'h0, reg_idx, 4'h0));
        else                 emit(enc(4'h9, 4'h0, 4'h0, reg_idx));
        emit(bcc(tf, fs, 1));
        emit(enc(4'hA, 4'h5, 4'd5, 4'd1));
        st(4'd5);
    endtask

    task automatic t_branch();
        logic [15:0] exp [5];
        clear_img();
        img[128] = 16'h8000;
        img[129] = 16'h0000;
        mkbase(4'd14, 4'd8);
        mkbase(4'd13, 4'd9);
        emit(enc(4'hA, 4'h5, 4'd0, 4'd0));
        emit(enc(4'h3, 4'h0, 4'd1, 4'd14));
        emit(enc(4'hA, 4'h0, 4'd14, 4'd2));
        cond_block(4'h8, 4'd0, 1'b1, 1'b0);
        cond_block(4'h8, 4'd0, 1'b1, 1'b1);
        cond_block(4'h8, 4'd1, 1'b1, 1'b1);
        cond_block(4'h8, 4'd1, 1'b0, 1'b0);
        cond_block(4'h9, 4'd14, 1'b0, 1'b0);
        halt();
        exp = '{16'd0, 16'd1, 16'd0, 16'd0, 16'd1};
        run_prog();
        for (int i = 0; i < 5; i++)
            check($sformatf("R7 R8 test and branch block %0d", i), out_word(i), exp[i]);
    endtask

    task automatic irq_block();
        emit(enc(4'hA, 4'h5, 4'd5, 4'd0));
        emit(birq(1));
        emit(enc(4'hA, 4'h5, 4'd5, 4'd1));
        st(4'd5);
    endtask

    task automatic t_irq(logic level);
        clear_img();
        mkbase(4'd13, 4'd9);
        irq_block();
        emit(16'h1000);
        irq_block();
        emit(16'h2000);
        irq_block();
        halt();
        irq_req = level;
        run_prog();
        irq_req = 1'b0;
        check("R9 branch-if-irq after reset", out_word(0), 16'd1);
        check("R9 branch-if-irq after enable", out_word(1), level ? 16'd0 : 16'd1);
        check("R9 branch-if-irq after disable", out_word(2), 16'd1);
    endtask

    task automatic t_io();
        clear_img();
        img[128] = 16'h5678;
        mkbase(4'd14, 4'd8);
        mkbase(4'd13, 4'd9);
        emit(enc(4'hC, 4'h0, 4'd1, 4'd14)); st(4'd1);
        emit(enc(4'h3, 4'h0, 4'd2, 4'd14));
        emit(enc(4'hD, 4'h0, 4'd2, 4'd14));
        halt();
        run_prog();
        check("R10 io read zero-extended", out_word(0), 16'h00C3);
        check("R10 io read address", ior_addr, 16'h0100);
        check("R10 io write count", 16'(iow_cnt), 16'd1);
        check("R10 io write address", iow_addr, 16'h0100);
        check("R10 io write data", {8'h00, iow_data}, 16'h0078);
        check("R10 io write leaves memory", mem[128], 16'h5678);
    endtask

    task automatic t_misc();
        clear_img();
        mkbase(4'd13, 4'd9);
        emit(enc(4'hA, 4'h5, 4'd1, 4'd9));
        emit(16'h0ABC);
        st(4'd1);
        emit(enc(4'h3, 4'h0, 4'd2, 4'd15));
        emit(16'h0DEF);
        st(4'd2);
        emit(16'hF000);
        emit(enc(4'hA, 4'h5, 4'd5, 4'd0));
        mkbase(4'd6, 4'd6);
        emit(enc(4'h7, 4'h5, 4'd15, 4'd6));
        emit(enc(4'hA, 4'h5, 4'd5, 4'd1));
        st(4'd5);
        halt();
        org = 16'hC0;
        st(4'd5);
        halt();
        run_prog();
        check("R11 nop leaves register", out_word(0), 16'd9);
        check("R12 read via pc returns next word", out_word(1), 16'h0DEF);
        check("R12 write to pc jumps", out_word(2), 16'd0);
        check("R11 bus reset pulse count", 16'(brst_cnt), 16'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL R2 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_alu();
        t_bytes();
        t_branch();
        t_irq(1'b1);
        t_irq(1'b0);
        t_io();
        t_misc();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule